// File: doc/BRIEF.md
# Variable-Page Translation Lookaside Buffer

This block is a small, fully associative translation cache for a device-side memory management unit. A device presents a 32-bit virtual address, and the block returns a physical address and access attributes one cycle later. Every entry can hold a 4 KB, 64 KB, 1 MB or 16 MB page. The page size of each entry sets which address bits it compares and which address bits pass through unchanged.

Software sets the block up through a word-addressed register port. To load an entry, it stages a tag word and a data word, picks a slot through the replacement register, and writes the load strobe. The same slot selection lets software read an entry back. An entry can be invalidated by virtual address. A bulk invalidate clears every entry that is not marked as kept.

A lookup that finds no entry raises a miss status bit. A lookup that finds two or more entries raises a separate multi-hit status bit. In both cases the address is captured. Status bits are cleared by writing 1 to them. The interrupt line shows the status bits that are enabled.

Top module: `iotlb_top`

## Requirements
- R1: Tag word layout: bits 31:12 hold the virtual tag, bit 3 is the keep bit, bit 2 is the valid bit, and bits 1:0 hold the page size code. Only an entry whose valid bit is 1 can match a lookup.
- R2: The page size code selects the compare mask: code 2 selects 0xFFFFF000 (4 KB), code 1 selects 0xFFFF0000 (64 KB), code 0 selects 0xFFF00000 (1 MB), and code 3 selects 0xFF000000 (16 MB). An entry matches when the lookup address and the tag agree on every bit of the mask. Tag bits outside the mask are ignored.
- R3: Data word layout: bits 31:12 hold the physical base, bit 9 is big-endian, bits 8:7 hold the element size, and bit 6 is the mixed flag. On a hit, the physical address is the base under the mask OR-ed with the lookup address bits outside the mask, and the three attributes are output.
- R4: The replacement register (offset 0x10) holds the victim index at bits starting at 4 and the floor index at bits starting at 10. A write to offset 0x1C loads the staged tag word (offset 0x14) and the staged data word (offset 0x18) into the victim slot. The victim index then advances by one, or wraps to the floor index after the last slot.
- R5: Offsets 0x28 and 0x2C read back the tag word and the data word stored at the current victim slot.
- R6: A write to offset 0x24 clears the valid bit of every entry whose tag matches the written address under that entry's own mask.
- R7: A write to offset 0x20 clears the valid bit of every entry whose keep bit is 0. Entries whose keep bit is 1 stay valid.
- R8: When translation is on and no entry matches, the result has hit=0 and address 0. Status bit 0 is set, and the address is captured into the fault register (offset 0x0C).
- R9: When translation is on and two or more entries match, the result has hit=0 and address 0. Status bit 4 is set, and the address is captured into the fault register.
- R10: The status register (offset 0x04) clears a bit when 1 is written to it. If a hardware set and a clear of the same bit happen in the same cycle, the set wins.
- R11: The interrupt output is the OR of the status bits AND-ed with the enable register (offset 0x08). The enable register uses the same bit layout as the status register.
- R12: The control register (offset 0x00) holds translation-on at bit 1 and walk-enable at bit 2. While translation is off, a lookup returns hit=1, a physical address equal to the virtual address, and all attributes 0, and it changes no status bit.
- R13: A lookup request in one cycle gives exactly one result-valid pulse in the next cycle. After reset, all entries are empty, and status, enable, control and fault registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| xlReq | input | 1 | Lookup request |
| xlVaddr | input | 32 | Virtual address to translate |
| xlDone | output | 1 | Lookup result valid |
| xlHit | output | 1 | Translation succeeded |
| xlPaddr | output | 32 | Physical address |
| xlBigEndian | output | 1 | Endianness attribute |
| xlElemSize | output | 2 | Element size attribute |
| xlMixed | output | 1 | Mixed-page attribute |
| irq | output | 1 | Interrupt |

## Verification
A software write that clears a status bit can land in the same cycle as a lookup that sets that bit. The bench forces this by raising the clearing write and a missing lookup on the same clock edge, while the miss bit is already set. It then checks that the bit reads back as 1 (R10). A second overlap is a lookup against two overlapping pages. The bench loads a 1 MB entry over an existing 4 KB entry, then expects both a multi-hit result and a single-hit result at addresses just inside and just outside the smaller page.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;
  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_STAT   = 8'h04;
  localparam logic [7:0] OFS_EN     = 8'h08;
  localparam logic [7:0] OFS_FAULT  = 8'h0C;
  localparam logic [7:0] OFS_REPL   = 8'h10;
  localparam logic [7:0] OFS_TAGSTG = 8'h14;
  localparam logic [7:0] OFS_DATSTG = 8'h18;
  localparam logic [7:0] OFS_LOAD   = 8'h1C;
  localparam logic [7:0] OFS_BULK   = 8'h20;
  localparam logic [7:0] OFS_ONE    = 8'h24;
  localparam logic [7:0] OFS_RBTAG  = 8'h28;
  localparam logic [7:0] OFS_RBDAT  = 8'h2C;

  localparam int VICT_LSB = 4;
  localparam int FLOOR_LSB = 10;
  localparam int STAT_W = 5;

  localparam logic [31:0] TAG_KEEP_MASK = 32'hFFFFF00F;
  localparam logic [31:0] DAT_KEEP_MASK = 32'hFFFFF3C0;

  typedef struct packed {
    logic load;
    logic bulkInv;
    logic oneInv;
  } tlbCmd_t;

  function automatic logic [31:0] pageMask(input logic [1:0] sizeCode);
    case (sizeCode)
      2'd0:    pageMask = 32'hFFF00000;
      2'd1:    pageMask = 32'hFFFF0000;
      2'd2:    pageMask = 32'hFFFFF000;
      default: pageMask = 32'hFF000000;
    endcase
  endfunction
endpackage

// File: rtl/iotlb_dpath.sv
module iotlb_dpath import iotlb_pkg::*; #(
  parameter int NUM_ENTRIES = 8,
  localparam int IW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  tlbCmd_t       cmd,
  input  logic [IW-1:0] victIdx,
  input  logic [31:0]   tagStage,
  input  logic [31:0]   datStage,
  input  logic [31:0]   invAddr,
  input  logic [31:0]   lkVaddr,
  output logic          lkHit,
  output logic          lkMulti,
  output logic [31:0]   lkPaddr,
  output logic          lkBig,
  output logic [1:0]    lkElem,
  output logic          lkMixed,
  output logic [31:0]   rbTag,
  output logic [31:0]   rbDat
);
  logic [31:0] tagQ [NUM_ENTRIES];
  logic [31:0] datQ [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] hitVec;
  logic [NUM_ENTRIES-1:0] invVec;

  // per-entry compare, each under its own page mask
  generate
    for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_cmp
      logic [31:0] eMask;
      assign eMask = pageMask(tagQ[gi][1:0]);
      assign hitVec[gi] = tagQ[gi][2] && (((lkVaddr ^ tagQ[gi]) & eMask) == 32'd0);
      assign invVec[gi] = (((invAddr ^ tagQ[gi]) & eMask) == 32'd0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        tagQ[i] <= '0;
        datQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (cmd.load && (victIdx == IW'(i))) begin
          tagQ[i] <= tagStage & TAG_KEEP_MASK;
          datQ[i] <= datStage & DAT_KEEP_MASK;
        end else if (cmd.bulkInv && !tagQ[i][3]) begin
          tagQ[i][2] <= 1'b0;
        end else if (cmd.oneInv && invVec[i]) begin
          tagQ[i][2] <= 1'b0;
        end
      end
    end
  end

  logic [31:0] selMask, selDat;
  always_comb begin
    selMask = '0;
    selDat  = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (hitVec[i]) begin
        selMask = selMask | pageMask(tagQ[i][1:0]);
        selDat  = selDat | datQ[i];
      end
    end
  end

  assign lkMulti = (hitVec & (hitVec - 1'b1)) != '0;
  assign lkHit   = (hitVec != '0) && !lkMulti;
  assign lkPaddr = lkHit ? ((selDat & selMask) | (lkVaddr & ~selMask)) : 32'd0;
  assign lkBig   = lkHit && selDat[9];
  assign lkElem  = lkHit ? selDat[8:7] : 2'd0;
  assign lkMixed = lkHit && selDat[6];
  assign rbTag   = tagQ[victIdx];
  assign rbDat   = datQ[victIdx];
endmodule

// File: rtl/iotlb_ctrl.sv
module iotlb_ctrl import iotlb_pkg::*; #(
  parameter int NUM_ENTRIES = 8,
  localparam int IW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWr,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              xlReq,
  input  logic [31:0]       xlVaddr,
  output logic              xlDone,
  output logic              xlHit,
  output logic [31:0]       xlPaddr,
  output logic              xlBigEndian,
  output logic [1:0]        xlElemSize,
  output logic              xlMixed,
  output logic              irq,
  output tlbCmd_t           cmd,
  output logic [IW-1:0]     victIdx,
  output logic [31:0]       tagStage,
  output logic [31:0]       datStage,
  output logic [31:0]       invAddr,
  input  logic              lkHit,
  input  logic              lkMulti,
  input  logic [31:0]       lkPaddr,
  input  logic              lkBig,
  input  logic [1:0]        lkElem,
  input  logic              lkMixed,
  input  logic [31:0]       rbTag,
  input  logic [31:0]       rbDat,
  output logic [STAT_W-1:0] statVal,
  output logic [STAT_W-1:0] enVal,
  output logic [31:0]       faultVal,
  output logic              mmuOn
);
  logic [STAT_W-1:0] statQ, enQ;
  logic [31:0]       faultQ;
  logic              onQ, walkQ;
  logic [IW-1:0]     victQ, floorQ;

  logic wrCtrl, wrStat, wrEn, wrRepl;
  assign wrCtrl = regWr && (regAddr == OFS_CTRL);
  assign wrStat = regWr && (regAddr == OFS_STAT);
  assign wrEn   = regWr && (regAddr == OFS_EN);
  assign wrRepl = regWr && (regAddr == OFS_REPL);

  assign cmd.load    = regWr && (regAddr == OFS_LOAD);
  assign cmd.bulkInv = regWr && (regAddr == OFS_BULK);
  assign cmd.oneInv  = regWr && (regAddr == OFS_ONE);
  assign invAddr     = regWdata;

  logic missEvt, multiEvt;
  assign missEvt  = xlReq && onQ && !lkHit && !lkMulti;
  assign multiEvt = xlReq && onQ && lkMulti;

  logic [STAT_W-1:0] setBits, clrBits;
  always_comb begin
    setBits = '0;
    setBits[0] = missEvt;
    setBits[4] = multiEvt;
    clrBits = wrStat ? regWdata[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statQ    <= '0;
      enQ      <= '0;
      faultQ   <= '0;
      onQ      <= 1'b0;
      walkQ    <= 1'b0;
      victQ    <= '0;
      floorQ   <= '0;
      tagStage <= '0;
      datStage <= '0;
    end else begin
      statQ <= (statQ & ~clrBits) | setBits;
      if (missEvt || multiEvt) faultQ <= xlVaddr;
      if (wrEn) enQ <= regWdata[STAT_W-1:0];
      if (wrCtrl) begin
        onQ   <= regWdata[1];
        walkQ <= regWdata[2];
      end
      if (regWr && (regAddr == OFS_TAGSTG)) tagStage <= regWdata;
      if (regWr && (regAddr == OFS_DATSTG)) datStage <= regWdata;
      if (wrRepl) begin
        victQ  <= regWdata[VICT_LSB +: IW];
        floorQ <= regWdata[FLOOR_LSB +: IW];
      end else if (cmd.load) begin
        victQ <= (victQ == IW'(NUM_ENTRIES - 1)) ? floorQ : victQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xlDone      <= 1'b0;
      xlHit       <= 1'b0;
      xlPaddr     <= '0;
      xlBigEndian <= 1'b0;
      xlElemSize  <= '0;
      xlMixed     <= 1'b0;
    end else begin
      xlDone <= xlReq;
      if (xlReq) begin
        if (!onQ) begin
          xlHit       <= 1'b1;
          xlPaddr     <= xlVaddr;
          xlBigEndian <= 1'b0;
          xlElemSize  <= 2'd0;
          xlMixed     <= 1'b0;
        end else begin
          xlHit       <= lkHit;
          xlPaddr     <= lkPaddr;
          xlBigEndian <= lkBig;
          xlElemSize  <= lkElem;
          xlMixed     <= lkMixed;
        end
      end
    end
  end

  always_comb begin
    case (regAddr)
      OFS_CTRL:   regRdata = {29'd0, walkQ, onQ, 1'b0};
      OFS_STAT:   regRdata = 32'(statQ);
      OFS_EN:     regRdata = 32'(enQ);
      OFS_FAULT:  regRdata = faultQ;
      OFS_REPL:   regRdata = (32'(floorQ) << FLOOR_LSB) | (32'(victQ) << VICT_LSB);
      OFS_TAGSTG: regRdata = tagStage;
      OFS_DATSTG: regRdata = datStage;
      OFS_RBTAG:  regRdata = rbTag;
      OFS_RBDAT:  regRdata = rbDat;
      default:    regRdata = 32'd0;
    endcase
  end

  assign irq      = |(statQ & enQ);
  assign victIdx  = victQ;
  assign statVal  = statQ;
  assign enVal    = enQ;
  assign faultVal = faultQ;
  assign mmuOn    = onQ;
endmodule

// File: rtl/iotlb_top.sv
module iotlb_top import iotlb_pkg::*; #(
  parameter int NUM_ENTRIES = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        regWr,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        xlReq,
  input  logic [31:0] xlVaddr,
  output logic        xlDone,
  output logic        xlHit,
  output logic [31:0] xlPaddr,
  output logic        xlBigEndian,
  output logic [1:0]  xlElemSize,
  output logic        xlMixed,
  output logic        irq
);
  localparam int IW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  tlbCmd_t           cmd;
  logic [IW-1:0]     victIdx;
  logic [31:0]       tagStage, datStage, invAddr;
  logic              lkHit, lkMulti, lkBig, lkMixed;
  logic [31:0]       lkPaddr, rbTag, rbDat;
  logic [1:0]        lkElem;
  logic [STAT_W-1:0] statVal, enVal;
  logic [31:0]       faultVal;
  logic              mmuOn;

  iotlb_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) i_ctrl (
    .clk(clk), .rst(rst), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .xlReq(xlReq), .xlVaddr(xlVaddr), .xlDone(xlDone),
    .xlHit(xlHit), .xlPaddr(xlPaddr), .xlBigEndian(xlBigEndian),
    .xlElemSize(xlElemSize), .xlMixed(xlMixed), .irq(irq), .cmd(cmd),
    .victIdx(victIdx), .tagStage(tagStage), .datStage(datStage), .invAddr(invAddr),
    .lkHit(lkHit), .lkMulti(lkMulti), .lkPaddr(lkPaddr), .lkBig(lkBig),
    .lkElem(lkElem), .lkMixed(lkMixed), .rbTag(rbTag), .rbDat(rbDat),
    .statVal(statVal), .enVal(enVal), .faultVal(faultVal), .mmuOn(mmuOn)
  );

  iotlb_dpath #(.NUM_ENTRIES(NUM_ENTRIES)) i_dpath (
    .clk(clk), .rst(rst), .cmd(cmd), .victIdx(victIdx), .tagStage(tagStage),
    .datStage(datStage), .invAddr(invAddr), .lkVaddr(xlVaddr), .lkHit(lkHit),
    .lkMulti(lkMulti), .lkPaddr(lkPaddr), .lkBig(lkBig), .lkElem(lkElem),
    .lkMixed(lkMixed), .rbTag(rbTag), .rbDat(rbDat)
  );
endmodule

// File: rtl/iotlb_chk.sv
module iotlb_chk (
  input logic        clk,
  input logic        rst,
  input logic        xlReq,
  input logic [31:0] xlVaddr,
  input logic        xlDone,
  input logic        xlHit,
  input logic [31:0] xlPaddr,
  input logic [4:0]  statVal,
  input logic [31:0] faultVal,
  input logic        mmuOn,
  input logic        irq
);
  p_result_follows_req_r13: assert property (@(posedge clk) disable iff (rst)
    xlReq |=> xlDone);
  p_no_spurious_result_r13: assert property (@(posedge clk) disable iff (rst)
    xlDone |-> $past(xlReq));
  p_failed_lookup_flags_r8: assert property (@(posedge clk) disable iff (rst)
    (xlDone && !xlHit) |-> (statVal[0] || statVal[4]));
  p_fault_addr_capture_r8: assert property (@(posedge clk) disable iff (rst)
    (xlDone && !xlHit) |-> (faultVal == $past(xlVaddr)));
  p_multi_no_xlate_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(statVal[4]) |-> (xlDone && !xlHit && xlPaddr == 32'd0));
  p_bypass_identity_r12: assert property (@(posedge clk) disable iff (rst)
    (xlDone && $past(!mmuOn)) |-> (xlHit && xlPaddr == $past(xlVaddr)));
  p_quiet_irq_r11: assert property (@(posedge clk) disable iff (rst)
    (statVal == 5'd0) |-> !irq);
endmodule

bind iotlb_top iotlb_chk i_chk (
  .clk(clk), .rst(rst), .xlReq(xlReq), .xlVaddr(xlVaddr), .xlDone(xlDone),
  .xlHit(xlHit), .xlPaddr(xlPaddr), .statVal(statVal), .faultVal(faultVal),
  .mmuOn(mmuOn), .irq(irq)
);

// File: tb/test_iotlb_top.sv
`timescale 1ns/1ps
module test_iotlb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWr = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        xlReq = 1'b0;
  logic [31:0] xlVaddr = '0;
  logic        xlDone, xlHit, xlBigEndian, xlMixed, irq;
  logic [31:0] xlPaddr;
  logic [1:0]  xlElemSize;

  always #4 clk = ~clk;

  iotlb_top #(.NUM_ENTRIES(8)) i_iotlb_top (
    .clk(clk), .rst(rst), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .xlReq(xlReq), .xlVaddr(xlVaddr), .xlDone(xlDone),
    .xlHit(xlHit), .xlPaddr(xlPaddr), .xlBigEndian(xlBigEndian),
    .xlElemSize(xlElemSize), .xlMixed(xlMixed), .irq(irq)
  );

  typedef struct {
    logic        hit;
    logic [31:0] pa;
    logic        big;
    logic [1:0]  elem;
    logic        mixed;
    string       req;
  } expItem_t;

  expItem_t sbQ[$];
  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // monitor: pops expected results as the design produces them
  always @(negedge clk) begin
    if (!rst && xlDone) begin
      if (sbQ.size() == 0) begin
        check32("R13 unexpected result", 32'd1, 32'd0);
      end else begin
        expItem_t e;
        e = sbQ.pop_front();
        check32({e.req, " hit"}, 32'(xlHit), 32'(e.hit));
        check32({e.req, " paddr"}, xlPaddr, e.pa);
        check32({e.req, " attrs"}, {28'd0, xlBigEndian, xlElemSize, xlMixed},
                {28'd0, e.big, e.elem, e.mixed});
      end
    end
  end

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic regExpect(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    regRead(a, v);
    check32(req, v, exp);
  endtask

  task automatic loadEntry(input logic [31:0] tagW, input logic [31:0] datW);
    regWrite(8'h14, tagW);
    regWrite(8'h18, datW);
    regWrite(8'h1C, 32'd1);
  endtask

  // driver: issues a lookup and queues its expected result
  task automatic xlate(input string req, input logic [31:0] va, input logic hit,
                       input logic [31:0] pa, input logic big, input logic [1:0] elem,
                       input logic mixed);
    expItem_t e;
    e.hit = hit; e.pa = pa; e.big = big; e.elem = elem; e.mixed = mixed; e.req = req;
    @(negedge clk);
    sbQ.push_back(e);
    xlReq = 1'b1; xlVaddr = va;
    @(negedge clk);
    xlReq = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 4 && sbQ.size() != 0; k++) @(negedge clk);
    check32("R13 queue drained", 32'(sbQ.size()), 32'd0);
  endtask

  initial begin
    for (int c = 0; c < 200000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R13 reset state
    regExpect("R13 status reset", 8'h04, 32'd0);
    regExpect("R13 fault reset", 8'h0C, 32'd0);
    regExpect("R13 tag slot reset", 8'h28, 32'd0);
    check32("R13 irq reset", 32'(irq), 32'd0);

    regWrite(8'h00, 32'h2);
    regExpect("R12 control readback", 8'h00, 32'h2);
    regWrite(8'h10, 32'h0);
    loadEntry(32'h12345006, 32'hABCDE340); // slot0: 4KB
    loadEntry(32'h20000005, 32'h30000080); // slot1: 64KB
    loadEntry(32'h4000000C, 32'h50000000); // slot2: 1MB kept
    loadEntry(32'h80ABC007, 32'h90123180); // slot3: 16MB, low tag bits ignored
    loadEntry(32'h60000002, 32'h61000000); // slot4: not valid
    regExpect("R4 victim advanced", 8'h10, 32'h50);
    regWrite(8'h10, 32'h10);
    regExpect("R5 readback tag slot1", 8'h28, 32'h20000005);
    regExpect("R5 readback data slot1", 8'h2C, 32'h30000080);

    xlate("R3 4KB hit", 32'h12345ABC, 1, 32'hABCDEABC, 1, 2'd2, 1);
    xlate("R2 4KB boundary miss", 32'h12346000, 0, 32'h0, 0, 2'd0, 0);
    xlate("R2 64KB hit", 32'h2000FFFF, 1, 32'h3000FFFF, 0, 2'd1, 0);
    xlate("R2 64KB boundary miss", 32'h20010000, 0, 32'h0, 0, 2'd0, 0);
    xlate("R2 1MB hit", 32'h400FFFFF, 1, 32'h500FFFFF, 0, 2'd0, 0);
    xlate("R2 16MB hit masked tag", 32'h80FFFFFF, 1, 32'h90FFFFFF, 0, 2'd3, 0);
    xlate("R1 invalid entry miss", 32'h60000123, 0, 32'h0, 0, 2'd0, 0);
    drain();
    regExpect("R8 miss status", 8'h04, 32'h1);
    regExpect("R8 fault address", 8'h0C, 32'h60000123);
    check32("R11 irq masked", 32'(irq), 32'd0);
    regWrite(8'h08, 32'h11);
    @(negedge clk);
    check32("R11 irq enabled", 32'(irq), 32'd1);

    // R10 clear and set in the same cycle: set wins
    begin
      expItem_t e;
      e.hit = 0; e.pa = 0; e.big = 0; e.elem = 0; e.mixed = 0; e.req = "R10 miss during clear";
      @(negedge clk);
      sbQ.push_back(e);
      regWr = 1'b1; regAddr = 8'h04; regWdata = 32'h1;
      xlReq = 1'b1; xlVaddr = 32'hDEAD0000;
      @(negedge clk);
      regWr = 1'b0; xlReq = 1'b0;
    end
    drain();
    regExpect("R10 set wins", 8'h04, 32'h1);
    regWrite(8'h04, 32'h1);
    regExpect("R10 write one clears", 8'h04, 32'h0);
    check32("R11 irq low after clear", 32'(irq), 32'd0);

    // R9 overlapping 1MB over slot0 4KB
    regWrite(8'h10, 32'h50);
    loadEntry(32'h12300004, 32'h70000000);
    xlate("R9 multi-hit", 32'h12345000, 0, 32'h0, 0, 2'd0, 0);
    xlate("R9 single outside small page", 32'h12300010, 1, 32'h70000010, 0, 2'd0, 0);
    drain();
    regExpect("R9 multi status", 8'h04, 32'h10);
    regExpect("R9 fault address", 8'h0C, 32'h12345000);
    check32("R11 irq on multi", 32'(irq), 32'd1);
    regWrite(8'h04, 32'h1F);

    // R4 wrap to floor
    regWrite(8'h10, (32'd6 << 10) | (32'd7 << 4));
    loadEntry(32'hA0000006, 32'hB0000000);
    regExpect("R4 wrap to floor", 8'h10, (32'd6 << 10) | (32'd6 << 4));
    regWrite(8'h10, (32'd6 << 10) | (32'd7 << 4));
    regExpect("R4 load at victim", 8'h28, 32'hA0000006);
    xlate("R4 loaded slot hit", 32'hA0000044, 1, 32'hB0000044, 0, 2'd0, 0);

    // R6 flush by address removes both overlapping entries
    regWrite(8'h24, 32'h12345000);
    xlate("R6 flushed 4KB", 32'h12345000, 0, 32'h0, 0, 2'd0, 0);
    xlate("R6 flushed 1MB", 32'h12300010, 0, 32'h0, 0, 2'd0, 0);
    xlate("R6 other entry kept", 32'h20000000, 1, 32'h30000000, 0, 2'd1, 0);

    // R7 bulk flush spares kept entries
    regWrite(8'h20, 32'd1);
    xlate("R7 kept entry survives", 32'h40000000, 1, 32'h50000000, 0, 2'd0, 0);
    xlate("R7 normal entry gone", 32'h80000000, 0, 32'h0, 0, 2'd0, 0);
    drain();
    regWrite(8'h04, 32'h1F);

    // R12 bypass
    regWrite(8'h00, 32'h0);
    xlate("R12 bypass", 32'h87654321, 1, 32'h87654321, 0, 2'd0, 0);
    drain();
    regExpect("R12 no status in bypass", 8'h04, 32'h0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule